// File: doc/BRIEF.md
# Interrupt Moderation Timer Unit

This unit sits between the event sources of a network controller and its interrupt cause register. Event sources present a vector of cause bits each cycle. The unit forwards these bits as a single cause-set pulse, and it limits how often such pulses can occur. The first batch of causes after a quiet period goes out in the same cycle it arrives. A hold-off countdown then starts. While the countdown runs, further causes are collected in a pending register. When the countdown reaches zero, the collected bits go out together and the countdown is armed again.

The hold-off length is recalculated every time a batch is posted, from the causes in that batch. There are three candidate delays:

- a transmit hold-off, which applies only when a transmit cause is present;
- a receive hold-off, which applies only when a receive-timer cause is present and a separate gate value is non-zero;
- a minimum gap, which always applies.

The smallest non-zero candidate is used. A zero value means "not set". If every candidate is zero, no hold-off is applied. The transmit and receive hold-offs count in units of four base ticks. The gap counts in single base ticks. The countdown advances only on a tick strobe supplied from outside. When the enable is low, the unit is bypassed: causes pass straight through and the countdown is frozen.

Top module: `imod_unit`

## Requirements
- R1: After reset, the pending register is zero and the countdown is idle. All four delay registers read zero, no pulse is output, and the first cause seen with moderation enabled is posted in that same cycle.
- R2: With `mod_en` low, `post_cause` equals `cause_in` and `post_valid` equals "`cause_in` is non-zero" in the same cycle. Causes are not accumulated and no hold-off applies, so the same cause in back-to-back cycles is posted in both cycles.
- R3: With `mod_en` high and the countdown idle, a non-zero `cause_in`, merged with any pending bits, is posted in the same cycle. The hold-off delay is then chosen from that merged vector.
- R4: While the countdown runs, incoming causes are only ORed into the pending register and nothing is posted. At expiry, the pending bits are posted and the countdown is re-armed from them. If nothing is pending at expiry, nothing is posted and the countdown becomes idle.
- R5: The transmit hold-off (selector 2) is a candidate only when cause bit 0 or bit 1 is in the merged vector. Its value is multiplied by 4, and the multiplied value is kept beyond 16 bits (for example, 0x4001 becomes 65540 ticks).
- R6: The receive hold-off (selector 1), multiplied by 4, is a candidate only when cause bit 7 is in the merged vector and the receive gate (selector 0) is non-zero.
- R7: The gap value (selector 3) is always a candidate and is used in single ticks. The chosen delay is the smallest non-zero candidate. If all candidates are zero, the next cause is posted immediately.
- R8: The countdown decrements only in cycles where `tick` is high. Consider a delay D armed at the end of a posting cycle, with `tick` high every cycle. The next post cannot happen earlier than D+1 cycles after the posting cycle, and it happens exactly then if anything is pending.
- R9: If a new cause arrives in the same cycle as expiry, it is merged into the post of that cycle and is not lost or delayed.
- R10: A write stores only the low 16 bits of `cfg_wdata` in the register picked by `cfg_addr`. `cfg_rdata` returns the stored value of the addressed register, zero-extended, and the write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | 1 = moderation active, 0 = bypass |
| tick | input | 1 | Base timebase strobe that advances the countdown |
| cause_in | input | 32 | Cause bits raised by event sources this cycle |
| cfg_we | input | 1 | Delay register write strobe |
| cfg_addr | input | 2 | Register select: 0 receive gate, 1 receive hold-off, 2 transmit hold-off, 3 gap |
| cfg_wdata | input | 32 | Write data (low 16 bits kept) |
| cfg_rdata | output | 32 | Stored value of the selected register |
| post_valid | output | 1 | Cause-set pulse |
| post_cause | output | 32 | Merged cause vector carried by the pulse |

## Verification
Expiry of the countdown and the arrival of a fresh cause can fall in the same cycle. The risk is that the fresh bits could be dropped, or posted twice with a second hold-off. The bench provokes this by arming a short gap and driving a new cause in exactly the cycle the countdown reads zero. It judges the outcome by requiring a single pulse in that cycle that carries the new bits, followed by silence through the re-armed window and then an immediate post once the countdown is idle again.

// File: rtl/imod_pkg.sv
`timescale 1ns/1ps
package imod_pkg;

    localparam int unsigned CAUSE_W      = 32;
    localparam int unsigned BUS_W        = 32;
    localparam int unsigned HOLD_W       = 16;
    localparam int unsigned COARSE_SHIFT = 2;
    localparam int unsigned CNT_W        = HOLD_W + COARSE_SHIFT;
    localparam int unsigned N_CFG        = 4;
    localparam int unsigned SEL_W        = $clog2(N_CFG);

    localparam int unsigned TX_DONE_BIT  = 0;
    localparam int unsigned TX_EMPTY_BIT = 1;
    localparam int unsigned RX_TMR_BIT   = 7;

    typedef logic [CNT_W-1:0]   ticks_t;
    typedef logic [HOLD_W-1:0]  hold_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_RX_GATE = SEL_W'(0),
        SEL_RX_HOLD = SEL_W'(1),
        SEL_TX_HOLD = SEL_W'(2),
        SEL_GAP     = SEL_W'(3)
    } cfg_sel_e;

    typedef struct packed {
        hold_t gap;
        hold_t tx_hold;
        hold_t rx_hold;
        hold_t rx_gate;
    } hold_cfg_t;

    typedef struct packed {
        logic tx_any;
        logic rx_tmr;
    } class_flags_t;

    typedef enum logic [1:0] {
        STEP_BYPASS,
        STEP_POST,
        STEP_COLLECT,
        STEP_SETTLE
    } step_e;

    function automatic ticks_t keep_shorter(ticks_t cur, ticks_t cand);
        if (cand != '0 && (cur == '0 || cand < cur)) begin
            return cand;
        end
        return cur;
    endfunction

    function automatic ticks_t coarse_to_ticks(hold_t v);
        return {v, {COARSE_SHIFT{1'b0}}};
    endfunction

    function automatic ticks_t fine_to_ticks(hold_t v);
        return {{COARSE_SHIFT{1'b0}}, v};
    endfunction

endpackage

// File: rtl/imod_cfg_regs.sv
`timescale 1ns/1ps
module imod_cfg_regs
    import imod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output hold_cfg_t        cfg
);

    hold_t regs [N_CFG];

    generate
        for (genvar g = 0; g < N_CFG; g++) begin : g_slot
            hold_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && addr == SEL_W'(g)) begin
                    q <= wdata[HOLD_W-1:0];
                end
            end
            assign regs[g] = q;
        end
    endgenerate

    logic unused_hi;
    assign unused_hi = ^wdata[BUS_W-1:HOLD_W];

    assign rdata = BUS_W'(regs[addr]);

    always_comb begin
        cfg.rx_gate = regs[SEL_RX_GATE];
        cfg.rx_hold = regs[SEL_RX_HOLD];
        cfg.tx_hold = regs[SEL_TX_HOLD];
        cfg.gap     = regs[SEL_GAP];
    end

endmodule

// File: rtl/imod_delay_sel.sv
`timescale 1ns/1ps
module imod_delay_sel
    import imod_pkg::*;
(
    input  hold_cfg_t    cfg,
    input  class_flags_t flags,
    output ticks_t       delay
);

    ticks_t tx_cand;
    ticks_t rx_cand;
    ticks_t gap_cand;

    always_comb begin
        tx_cand  = flags.tx_any ? coarse_to_ticks(cfg.tx_hold) : '0;
        rx_cand  = (flags.rx_tmr && cfg.rx_gate != '0) ? coarse_to_ticks(cfg.rx_hold) : '0;
        gap_cand = fine_to_ticks(cfg.gap);
        delay    = '0;
        delay    = keep_shorter(delay, tx_cand);
        delay    = keep_shorter(delay, rx_cand);
        delay    = keep_shorter(delay, gap_cand);
    end

endmodule

// File: rtl/imod_countdown.sv
`timescale 1ns/1ps
module imod_countdown
    import imod_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  logic   tick,
    input  logic   seq,
    input  logic   arm,
    input  ticks_t arm_val,
    output logic   running,
    output ticks_t count,
    output logic   expired
);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count   <= '0;
        end else if (!hold) begin
            if (seq) begin
                running <= arm;
                count   <= arm ? arm_val : '0;
            end else if (running && tick && count != '0) begin
                count <= count - ticks_t'(1);
            end
        end
    end

    assign expired = running && (count == '0);

endmodule

// File: rtl/imod_unit.sv
`timescale 1ns/1ps
module imod_unit
    import imod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mod_en,
    input  logic               tick,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_addr,
    input  logic [BUS_W-1:0]   cfg_wdata,
    output logic [BUS_W-1:0]   cfg_rdata,
    output logic               post_valid,
    output logic [CAUSE_W-1:0] post_cause
);

    hold_cfg_t    cfg;
    cause_t       pend_q;
    cause_t       merged;
    class_flags_t flags;
    ticks_t       delay;
    logic         t_running;
    ticks_t       t_count;
    logic         t_expired;
    logic         seq;
    logic         arm;
    step_e        step;

    imod_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    assign merged       = pend_q | cause_in;
    assign flags.tx_any = merged[TX_DONE_BIT] | merged[TX_EMPTY_BIT];
    assign flags.rx_tmr = merged[RX_TMR_BIT];

    imod_delay_sel u_sel (
        .cfg   (cfg),
        .flags (flags),
        .delay (delay)
    );

    always_comb begin
        if (!mod_en) begin
            step = STEP_BYPASS;
        end else if (t_running && !t_expired) begin
            step = STEP_COLLECT;
        end else if (merged != '0) begin
            step = STEP_POST;
        end else begin
            step = STEP_SETTLE;
        end
    end

    assign seq = (step == STEP_POST) || (step == STEP_SETTLE);
    assign arm = (step == STEP_POST) && (delay != '0);

    imod_countdown u_cnt (
        .clk     (clk),
        .rst     (rst),
        .hold    (step == STEP_BYPASS),
        .tick    (tick),
        .seq     (seq),
        .arm     (arm),
        .arm_val (delay),
        .running (t_running),
        .count   (t_count),
        .expired (t_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            case (step)
                STEP_COLLECT: pend_q <= merged;
                STEP_POST,
                STEP_SETTLE:  pend_q <= '0;
                default:      pend_q <= pend_q;
            endcase
        end
    end

    always_comb begin
        case (step)
            STEP_BYPASS: begin
                post_valid = (cause_in != '0);
                post_cause = cause_in;
            end
            STEP_POST: begin
                post_valid = 1'b1;
                post_cause = merged;
            end
            default: begin
                post_valid = 1'b0;
                post_cause = '0;
            end
        endcase
    end

endmodule

// File: rtl/imod_unit_chk.sv
`timescale 1ns/1ps
module imod_unit_chk
    import imod_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mod_en,
    input logic               tick,
    input logic [CAUSE_W-1:0] cause_in,
    input logic               post_valid,
    input logic [CAUSE_W-1:0] post_cause,
    input logic [BUS_W-1:0]   cfg_rdata,
    input logic               running,
    input ticks_t             count,
    input cause_t             pend
);

    // R1: reset leaves the countdown idle and nothing pending
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!running && pend == '0));

    // R2: bypass forwards the input unchanged
    p_bypass_pass_r2: assert property (@(posedge clk) disable iff (rst)
        !mod_en |-> (post_cause == cause_in && post_valid == (cause_in != '0)));

    // R3: idle countdown posts a new cause at once and carries all of its bits
    p_idle_post_r3: assert property (@(posedge clk) disable iff (rst)
        (mod_en && !running && cause_in != '0) |-> (post_valid && (post_cause & cause_in) == cause_in));

    // R4: no pulse while the countdown is still above zero
    p_quiet_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mod_en && running && count != '0) |-> !post_valid);

    // R4 and R9: expiry posts pending merged with the fresh input
    p_expiry_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (mod_en && running && count == '0 && (pend | cause_in) != '0) |-> (post_valid && post_cause == (pend | cause_in)));

    // R8: without a tick the countdown holds its value
    p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mod_en && running && count != '0 && !tick) |=> (count == $past(count)));

    // R7: arming never starts with a zero count
    p_arm_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (count != '0));

    // R10: read data is zero-extended from 16 bits
    p_rdata_width_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[BUS_W-1:HOLD_W] == '0);

endmodule

bind imod_unit imod_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mod_en     (mod_en),
    .tick       (tick),
    .cause_in   (cause_in),
    .post_valid (post_valid),
    .post_cause (post_cause),
    .cfg_rdata  (cfg_rdata),
    .running    (t_running),
    .count      (t_count),
    .pend       (pend_q)
);

// File: tb/imod_unit_test.sv
`timescale 1ns/1ps
module imod_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_en = 1'b1;
    logic        tick = 1'b1;
    logic [31:0] cause_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        post_valid;
    logic [31:0] post_cause;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] c;
        int          at;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    imod_unit uut (
        .clk        (clk),
        .rst        (rst),
        .mod_en     (mod_en),
        .tick       (tick),
        .cause_in   (cause_in),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .post_valid (post_valid),
        .post_cause (post_cause)
    );

    task automatic check(input string r, input logic [31:0] a, input logic [31:0] e);
        n_tests++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", r, a, e);
        end
    endtask

    task automatic push(input logic [31:0] c, input int at, input string r);
        exp_t x;
        x.c = c; x.at = at; x.req = r;
        sb.push_back(x);
    endtask

    task automatic go(input logic [31:0] c, input logic tk);
        @(posedge clk); #1;
        cfg_we = 1'b0; cause_in = c; tick = tk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) go(32'h0, 1'b1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cause_in = '0; tick = 1'b1;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string r);
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_addr = a; cause_in = '0;
        @(negedge clk);
        check(r, cfg_rdata, e);
    endtask

    task automatic set_en(input logic v);
        @(posedge clk); #1;
        cfg_we = 1'b0; mod_en = v; cause_in = '0;
    endtask

    // scoreboard monitor: compares every pulse with the queue head
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (post_valid) begin
                    n_tests++;
                    if (sb.size() == 0) begin
                        n_fail++;
                        $display("FAIL R4: unexpected pulse at cycle %0d actual=%h expected=none", cyc, post_cause);
                    end else begin
                        e = sb.pop_front();
                        if (post_cause !== e.c || cyc != e.at) begin
                            n_fail++;
                            $display("FAIL %s: actual=%h@%0d expected=%h@%0d", e.req, post_cause, cyc, e.c, e.at);
                        end
                    end
                end
                while (sb.size() > 0 && sb[0].at <= cyc) begin
                    e = sb.pop_front();
                    n_tests++;
                    n_fail++;
                    $display("FAIL %s: actual=none@%0d expected=%h@%0d", e.req, cyc, e.c, e.at);
                end
            end
            cyc++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4: watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 no pulse after reset", {31'b0, post_valid}, 32'h0);
        rd(2'd0, 32'h0, "R1 gate reg reset");
        rd(2'd1, 32'h0, "R1 rx reg reset");
        rd(2'd2, 32'h0, "R1 tx reg reset");
        rd(2'd3, 32'h0, "R1 gap reg reset");

        // R1 / R7: all registers zero, every cause posts at once
        go(32'h0000_0004, 1'b1); c = cyc;
        push(32'h0000_0004, c, "R1");
        push(32'h0000_0030, c + 1, "R7");
        push(32'h0000_0030, c + 2, "R7");
        go(32'h0000_0030, 1'b1);
        go(32'h0000_0030, 1'b1);
        idle(5);

        // R3 / R4: gap of 3 ticks
        wr(2'd3, 32'd3);
        go(32'h0000_0004, 1'b1); c = cyc;
        push(32'h0000_0004, c, "R3");
        push(32'h0000_0110, c + 4, "R4");
        push(32'h0000_0020, c + 8, "R4");
        push(32'h0000_0040, c + 13, "R3");
        for (int i = 1; i <= 13; i++)
            go(i == 1 ? 32'h10 : i == 2 ? 32'h100 : i == 6 ? 32'h20 : i == 13 ? 32'h40 : 32'h0, 1'b1);
        idle(10);

        // R2: bypass with gap still 3
        set_en(1'b0);
        go(32'h0000_0003, 1'b1); c = cyc;
        push(32'h0000_0003, c, "R2");
        push(32'h0000_0003, c + 1, "R2");
        push(32'h0000_0080, c + 2, "R2");
        go(32'h0000_0003, 1'b1);
        go(32'h0000_0080, 1'b1);
        set_en(1'b1);
        idle(10);

        // R5: transmit hold-off 2 -> 8 ticks, gap 0
        wr(2'd3, 32'd0);
        wr(2'd2, 32'd2);
        go(32'h0000_0001, 1'b1); c = cyc;
        push(32'h0000_0001, c, "R5");
        push(32'h0000_0020, c + 9, "R5");
        push(32'h0000_0020, c + 10, "R5");
        push(32'h0000_0002, c + 11, "R5");
        push(32'h0000_0004, c + 20, "R5");
        for (int i = 1; i <= 12; i++)
            go(i == 1 ? 32'h20 : i == 10 ? 32'h20 : i == 11 ? 32'h2 : i == 12 ? 32'h4 : 32'h0, 1'b1);
        idle(20);

        // R7: smallest non-zero wins (tx 1 -> 4 ticks, gap 5)
        wr(2'd2, 32'd1);
        wr(2'd3, 32'd5);
        go(32'h0000_0001, 1'b1); c = cyc;
        push(32'h0000_0001, c, "R7");
        push(32'h0000_0200, c + 5, "R7");
        go(32'h0000_0200, 1'b1);
        idle(20);

        // R6: receive hold-off 1 -> 4 ticks, gap 6, gate zero then non-zero
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd1);
        wr(2'd3, 32'd6);
        go(32'h0000_0080, 1'b1); c = cyc;
        push(32'h0000_0080, c, "R6");
        push(32'h0000_0200, c + 7, "R6");
        go(32'h0000_0200, 1'b1);
        idle(20);
        wr(2'd0, 32'd1);
        go(32'h0000_0080, 1'b1); c = cyc;
        push(32'h0000_0080, c, "R6");
        push(32'h0000_0200, c + 5, "R6");
        go(32'h0000_0200, 1'b1);
        idle(20);

        // R10: only low 16 bits stored
        wr(2'd0, 32'd0);
        wr(2'd1, 32'hABCD_1234);
        wr(2'd3, 32'h0001_0002);
        rd(2'd1, 32'h0000_1234, "R10 rx readback");
        rd(2'd3, 32'h0000_0002, "R10 gap readback");
        wr(2'd1, 32'd0);
        go(32'h0000_0010, 1'b1); c = cyc;
        push(32'h0000_0010, c, "R10");
        push(32'h0000_0020, c + 3, "R10");
        go(32'h0000_0020, 1'b1);
        idle(10);

        // R9: cause lands in the expiry cycle (gap 2)
        go(32'h0000_0010, 1'b1); c = cyc;
        push(32'h0000_0010, c, "R9");
        push(32'h0000_0040, c + 3, "R9");
        push(32'h0000_0100, c + 7, "R9");
        for (int i = 1; i <= 7; i++)
            go(i == 3 ? 32'h40 : i == 7 ? 32'h100 : 32'h0, 1'b1);
        idle(10);

        // R8: countdown waits for ticks (gap 1)
        wr(2'd3, 32'd1);
        go(32'h0000_0010, 1'b1); c = cyc;
        push(32'h0000_0010, c, "R8");
        push(32'h0000_0020, c + 7, "R8");
        for (int i = 1; i <= 7; i++)
            go(i == 1 ? 32'h20 : 32'h0, i >= 6 ? 1'b1 : 1'b0);
        idle(10);

        // R5: scaled hold-off exceeds 16 bits (0x4001 -> 65540 ticks)
        wr(2'd3, 32'd0);
        wr(2'd2, 32'h0000_4001);
        go(32'h0000_0001, 1'b1); c = cyc;
        push(32'h0000_0001, c, "R5");
        push(32'h0000_0004, c + 65541, "R5");
        go(32'h0000_0004, 1'b1);
        idle(65550);

        idle(5);
        check("R4 scoreboard drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule